// File: doc/BRIEF.md
# UART Receive Idle Time-out and Line Break Guard

This block sits beside a UART receiver and its receive FIFO. It counts 16x baud ticks and raises a character time-out interrupt when the FIFO holds some data but less than the trigger level, and no further characters arrive for four character times. The length of a character time follows the programmed frame format, so the wait tracks data width, parity and stop bits.

The same tick stream drives a break detector. It emits a one-cycle pulse when the RX line has stayed low for longer than one full character. It then fires no more pulses until RX has been seen high again. A software break-control bit forces the serial output low for as long as the bit is set. The receiver shift logic and the FIFO are outside this block. The bench drives the FIFO level, the stop-bit-center strobe and the read strobe directly.

Top module: `uart_rx_guard`

## Requirements
- R1: The character time is (1 + D + P + S) x 16 ticks. D = 5 + data_bits_i, where code 0..3 selects 5..8 bits. P = parity_en_i. S = 1 + stop2_i.
- R2: While 0 < fifo_lvl_i < trig_lvl_i, tmo_irq_o rises at the clock edge that samples the (4 x character time)-th counted tick since the last restart. Cycles with tick16_i low are not counted.
- R3: A stop_mid_i strobe restarts the time-out count from zero.
- R4: A fifo_rd_i strobe restarts the time-out count from zero and clears tmo_irq_o at the next clock edge.
- R5: With fifo_lvl_i equal to 0, or fifo_lvl_i >= trig_lvl_i, the count is held at zero. A zero level also clears tmo_irq_o at the next clock edge.
- R6: brk_det_o pulses high for one cycle at the edge that samples the (character time + 1)-th consecutive tick with rx_i low. Ticks are counted only while tick16_i is high.
- R7: Only one pulse fires per low period of rx_i. Any cycle with rx_i high clears the low-run count and re-arms the detector.
- R8: tx_o is 0 whenever brk_ctl_i is 1, and otherwise equals tx_i in the same cycle.
- R9: After reset, tmo_irq_o and brk_det_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | 16x baud tick, one cycle wide |
| data_bits_i | input | 2 | Data width code, 0..3 = 5..8 bits |
| parity_en_i | input | 1 | Parity bit present |
| stop2_i | input | 1 | Two stop bits when 1 |
| stop_mid_i | input | 1 | Receiver strobe at stop-bit center |
| fifo_rd_i | input | 1 | Receive FIFO read strobe |
| fifo_lvl_i | input | LVL_W | Receive FIFO fill level |
| trig_lvl_i | input | LVL_W | Receive trigger level |
| rx_i | input | 1 | Serial receive line, synchronous to clk_i |
| brk_ctl_i | input | 1 | Software break request |
| tx_i | input | 1 | Serial data from the transmitter |
| tmo_irq_o | output | 1 | Character time-out interrupt |
| brk_det_o | output | 1 | Break detected pulse |
| tx_o | output | 1 | Serial output after break override |

## Verification
The time-out interrupt is registered. With a tick on every cycle, it is due on the L-th clock edge after the first counted tick, where L = 4 x character time. The bench samples at the falling edge after L-1 edges (expects 0) and after L edges (expects 1). Clears from a read or from an empty FIFO are due one edge after the strobe. The break pulse is due on the (C+1)-th edge of a low run, where C is the character time. The bench counts pulses over whole windows, so an early, late or repeated pulse is caught. tx_o is combinational and is checked in the same cycle as its inputs.

// File: rtl/uart_guard_pkg.sv
package uart_guard_pkg;
  typedef struct packed {
    logic [1:0] dsel;
    logic       par_en;
    logic       stop2;
  } frame_t;

  // start + data + parity + stop bits
  function automatic int unsigned frame_bits(frame_t f, int unsigned dmin);
    return 1 + dmin + 32'(f.dsel) + 32'(f.par_en) + 1 + 32'(f.stop2);
  endfunction
endpackage

// File: rtl/uart_char_len.sv
module uart_char_len
  import uart_guard_pkg::*;
#(
  parameter int unsigned OVS       = 16,
  parameter int unsigned DMIN      = 5,
  parameter int unsigned TMO_CHARS = 4,
  parameter int unsigned CNT_W     = 10
) (
  input  frame_t           frame_i,
  output logic [CNT_W-1:0] char_ticks_o,
  output logic [CNT_W-1:0] tmo_ticks_o
);
  int unsigned bits;

  always_comb begin
    bits         = frame_bits(frame_i, DMIN);
    char_ticks_o = CNT_W'(bits * OVS);
    tmo_ticks_o  = CNT_W'(bits * OVS * TMO_CHARS);
  end
endmodule

// File: rtl/uart_tmo_ctr.sv
module uart_tmo_ctr #(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned LVL_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic             rd_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0] trig_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;
  logic             armed;

  assign armed = (lvl_i != '0) && (lvl_i < trig_i);
  assign irq_o = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (rd_i || lvl_i == '0) irq_q <= 1'b0;
      if (restart_i || !armed) begin
        cnt_q <= '0;
      end else if (tick_i && !irq_q) begin
        if ((cnt_q + CNT_W'(1)) >= limit_i) begin
          cnt_q <= '0;
          irq_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/uart_brk_det.sv
module uart_brk_det #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             rx_i,
  input  logic [CNT_W-1:0] char_ticks_i,
  output logic             brk_o
);
  logic [CNT_W-1:0] lo_cnt_q;
  logic             armed_q;
  logic             brk_q;

  assign brk_o = brk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt_q <= '0;
      armed_q  <= 1'b1;
      brk_q    <= 1'b0;
    end else begin
      brk_q <= 1'b0;
      if (rx_i) begin
        lo_cnt_q <= '0;
        armed_q  <= 1'b1;
      end else if (tick_i) begin
        // saturate once a full character of low has been seen
        if (lo_cnt_q >= char_ticks_i) begin
          if (armed_q) begin
            brk_q   <= 1'b1;
            armed_q <= 1'b0;
          end
        end else begin
          lo_cnt_q <= lo_cnt_q + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_guard.sv
module uart_rx_guard
  import uart_guard_pkg::*;
#(
  parameter int unsigned OVS       = 16,
  parameter int unsigned DMIN      = 5,
  parameter int unsigned TMO_CHARS = 4,
  parameter int unsigned LVL_W     = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick16_i,
  input  logic [1:0]       data_bits_i,
  input  logic             parity_en_i,
  input  logic             stop2_i,
  input  logic             stop_mid_i,
  input  logic             fifo_rd_i,
  input  logic [LVL_W-1:0] fifo_lvl_i,
  input  logic [LVL_W-1:0] trig_lvl_i,
  input  logic             rx_i,
  input  logic             brk_ctl_i,
  input  logic             tx_i,
  output logic             tmo_irq_o,
  output logic             brk_det_o,
  output logic             tx_o
);
  localparam int unsigned MAX_BITS = 1 + DMIN + 3 + 1 + 2;
  localparam int unsigned CNT_W    = $clog2(MAX_BITS * OVS * TMO_CHARS + 1);

  frame_t           frame;
  logic [CNT_W-1:0] char_ticks;
  logic [CNT_W-1:0] tmo_ticks;

  assign frame = '{dsel: data_bits_i, par_en: parity_en_i, stop2: stop2_i};

  uart_char_len #(
    .OVS(OVS), .DMIN(DMIN), .TMO_CHARS(TMO_CHARS), .CNT_W(CNT_W)
  ) u_len (
    .frame_i     (frame),
    .char_ticks_o(char_ticks),
    .tmo_ticks_o (tmo_ticks)
  );

  uart_tmo_ctr #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_tmo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick16_i),
    .restart_i(stop_mid_i | fifo_rd_i),
    .rd_i     (fifo_rd_i),
    .lvl_i    (fifo_lvl_i),
    .trig_i   (trig_lvl_i),
    .limit_i  (tmo_ticks),
    .irq_o    (tmo_irq_o)
  );

  uart_brk_det #(.CNT_W(CNT_W)) u_brk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick16_i),
    .rx_i        (rx_i),
    .char_ticks_i(char_ticks),
    .brk_o       (brk_det_o)
  );

  assign tx_o = tx_i & ~brk_ctl_i;
endmodule

// File: rtl/uart_rx_guard_chk.sv
module uart_rx_guard_chk #(
  parameter int unsigned LVL_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick16_i,
  input logic             stop_mid_i,
  input logic             fifo_rd_i,
  input logic [LVL_W-1:0] fifo_lvl_i,
  input logic             rx_i,
  input logic             brk_ctl_i,
  input logic             tx_i,
  input logic             tmo_irq_o,
  input logic             brk_det_o,
  input logic             tx_o
);
  a_r2_irq_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmo_irq_o) |-> $past(tick16_i));

  a_r3_stop_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_mid_i |=> !$rose(tmo_irq_o));

  a_r4_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_i |=> !tmo_irq_o);

  a_r5_empty_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_lvl_i == '0) |=> !tmo_irq_o);

  a_r6_brk_on_low_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(brk_det_o) |-> $past(!rx_i && tick16_i));

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_det_o |=> !brk_det_o);

  a_r8_tx_forced_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_ctl_i |-> !tx_o);

  a_r8_tx_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !brk_ctl_i |-> (tx_o == tx_i));
endmodule

bind uart_rx_guard uart_rx_guard_chk #(.LVL_W(LVL_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick16_i  (tick16_i),
  .stop_mid_i(stop_mid_i),
  .fifo_rd_i (fifo_rd_i),
  .fifo_lvl_i(fifo_lvl_i),
  .rx_i      (rx_i),
  .brk_ctl_i (brk_ctl_i),
  .tx_i      (tx_i),
  .tmo_irq_o (tmo_irq_o),
  .brk_det_o (brk_det_o),
  .tx_o      (tx_o)
);

// File: tb/uart_rx_guard_test.sv
module uart_rx_guard_test;
  localparam int LVL_W = 7;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             tick16_i = 1'b0;
  logic [1:0]       data_bits_i = '0;
  logic             parity_en_i = 1'b0;
  logic             stop2_i = 1'b0;
  logic             stop_mid_i = 1'b0;
  logic             fifo_rd_i = 1'b0;
  logic [LVL_W-1:0] fifo_lvl_i = '0;
  logic [LVL_W-1:0] trig_lvl_i = '0;
  logic             rx_i = 1'b1;
  logic             brk_ctl_i = 1'b0;
  logic             tx_i = 1'b1;
  logic             tmo_irq_o, brk_det_o, tx_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_rx_guard #(.LVL_W(LVL_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick16_i(tick16_i),
    .data_bits_i(data_bits_i), .parity_en_i(parity_en_i), .stop2_i(stop2_i),
    .stop_mid_i(stop_mid_i), .fifo_rd_i(fifo_rd_i), .fifo_lvl_i(fifo_lvl_i),
    .trig_lvl_i(trig_lvl_i), .rx_i(rx_i), .brk_ctl_i(brk_ctl_i), .tx_i(tx_i),
    .tmo_irq_o(tmo_irq_o), .brk_det_o(brk_det_o), .tx_o(tx_o)
  );

  function automatic int exp_char(int d, int p, int s);
    return (1 + 5 + d + p + 1 + s) * 16;
  endfunction

  function automatic int exp_tmo(int d, int p, int s);
    return 4 * exp_char(d, p, s);
  endfunction

  task automatic chk(int got, int exp, string req, string what);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_brk(int n, output int ones);
    ones = 0;
    repeat (n) begin
      @(negedge clk);
      if (brk_det_o) ones++;
    end
  endtask

  task automatic clear_irq();
    fifo_rd_i = 1'b1;
    cyc(1);
    fifo_rd_i = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    end
    $finish;
  end

  initial begin
    int seed;
    int ones;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    // R9 reset state
    chk(tmo_irq_o, 0, "R9", "irq after reset");
    chk(brk_det_o, 0, "R9", "brk after reset");
    chk(tx_o, 1, "R9", "tx after reset");

    for (int t = 0; t < 6; t++) begin
      int d, p, s, trig, lvl, L, C;
      d = (t < 4) ? t : int'($urandom % 4);
      p = (t == 0) ? 0 : (t == 3) ? 1 : int'($urandom % 2);
      s = (t == 0) ? 0 : (t == 3) ? 1 : int'($urandom % 2);
      trig = 2 + int'($urandom % 60);
      lvl  = 1 + int'($urandom % (trig - 1));
      L = exp_tmo(d, p, s);
      C = exp_char(d, p, s);

      // ---- time-out path ----
      rx_i = 1'b1; tick16_i = 1'b0; fifo_lvl_i = '0;
      clear_irq();
      data_bits_i = 2'(d); parity_en_i = 1'(p); stop2_i = 1'(s);
      trig_lvl_i = LVL_W'(trig); fifo_lvl_i = LVL_W'(lvl);
      cyc(L + 40);
      chk(tmo_irq_o, 0, "R2", "no tick, no count");
      tick16_i = 1'b1;
      cyc(L - 1);
      chk(tmo_irq_o, 0, "R1", "one tick before limit");
      cyc(1);
      chk(tmo_irq_o, 1, "R2", "fires at limit");
      cyc(7);
      chk(tmo_irq_o, 1, "R2", "holds until read");
      clear_irq();
      chk(tmo_irq_o, 0, "R4", "read clears");

      cyc(L - 3);
      stop_mid_i = 1'b1; cyc(1); stop_mid_i = 1'b0;
      cyc(L - 1);
      chk(tmo_irq_o, 0, "R3", "stop center restarts");
      cyc(1);
      chk(tmo_irq_o, 1, "R3", "fires after restart");

      fifo_lvl_i = '0; cyc(1);
      chk(tmo_irq_o, 0, "R5", "empty clears");
      fifo_lvl_i = LVL_W'(lvl);
      cyc(L - 3);
      clear_irq();
      cyc(L - 1);
      chk(tmo_irq_o, 0, "R4", "read restarts");
      cyc(1);
      chk(tmo_irq_o, 1, "R4", "fires after read restart");
      clear_irq();

      fifo_lvl_i = LVL_W'(trig);
      cyc(L + 20);
      chk(tmo_irq_o, 0, "R5", "level at trigger");
      fifo_lvl_i = LVL_W'(lvl);
      cyc(L - 1);
      chk(tmo_irq_o, 0, "R5", "count held at zero");
      cyc(1);
      chk(tmo_irq_o, 1, "R5", "count resumes");
      fifo_lvl_i = '0;
      clear_irq();

      // ---- break path ----
      tick16_i = 1'b1; rx_i = 1'b0;
      count_brk(C, ones);
      chk(ones, 0, "R6", "no pulse within one character");
      cyc(1);
      chk(brk_det_o, 1, "R6", "pulse after one character");
      count_brk(300, ones);
      chk(ones, 0, "R7", "single pulse per low period");
      rx_i = 1'b1; cyc(1);
      rx_i = 1'b0;
      count_brk(C, ones);
      chk(ones, 0, "R7", "rearmed count restarts");
      cyc(1);
      chk(brk_det_o, 1, "R7", "pulse after rearm");
      rx_i = 1'b1; cyc(1);
      rx_i = 1'b0;
      count_brk(C, ones);
      rx_i = 1'b1;
      count_brk(4, ones);
      chk(ones, 0, "R7", "short low then high");
      rx_i = 1'b0; tick16_i = 1'b0;
      count_brk(C + 60, ones);
      chk(ones, 0, "R6", "no ticks, no break");
      rx_i = 1'b1;
      cyc(1);
    end

    // ---- TX override ----
    for (int k = 0; k < 24; k++) begin
      int b, x;
      b = int'($urandom % 2);
      x = int'($urandom % 2);
      brk_ctl_i = 1'(b); tx_i = 1'(x);
      #1;
      chk(tx_o, (b == 1) ? 0 : x, "R8", "tx override");
      cyc(1);
    end
    brk_ctl_i = 1'b1;
    ones = 0;
    for (int k = 0; k < 16; k++) begin
      tx_i = ~tx_i;
      cyc(1);
      if (tx_o) ones++;
    end
    chk(ones, 0, "R8", "tx held low while break set");
    brk_ctl_i = 1'b0; tx_i = 1'b1; #1;
    chk(tx_o, 1, "R8", "tx released");

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    end
    $finish;
  end
endmodule